// File: doc/BRIEF.md
# Page-Mode ROM Burst Read Controller

This block sits on the synchronous side of a chip and reads bursts from an external asynchronous parallel ROM. The ROM has no clock. A full random access is slow. Once the upper address is settled, other locations in the same page come out much faster. The ROM can be strapped per access to return 16-bit words or 8-bit bytes. In byte mode the most significant data pin turns into the lowest address input, and the controller drives it.

A request carries a start address, a beat count minus one and a mode bit. The controller drives chip enable, output enable, the mode pin and the address. It waits a programmable number of clocks for the first beat of each page, then steps only the in-page bits and waits the shorter page count for each further beat. It samples each beat before the address moves, and hands the beats out on a valid/ready stream with a last flag. A burst that runs past the end of a page continues with a full random access at the start of the next page. Between requests the ROM is held in standby. The bus stays quiet for a programmable turnaround before the next request is taken.

Top module: `prom_burst_ctrl`

## Requirements
- R1: After reset and between requests the controller holds `rom_ce_n` and `rom_oe_n` high, `req_ready` high and `out_valid` low. Whenever `rom_ce_n` is high, `rom_oe_n` is also high.
- R2: On the clock edge that accepts a request, `rom_ce_n` and `rom_oe_n` both go low and the start address appears on the pins. The first beat is captured `cfg_t_rand` clocks after that edge.
- R3: Each further beat in the same page changes only the page-offset bits (`rom_addr[2:0]`, and `rom_a_lsb` in byte mode) and is captured `cfg_t_page` clocks after the address step. Chip enable and `rom_addr[ADDR_W-1:3]` stay constant while this happens.
- R4: When the next beat's page offset is zero (8-word or 16-byte page), the controller does a full random access (`cfg_t_rand` clocks) for that beat and the same request continues. Address wrap past the top of memory is handled the same way.
- R5: Word mode (`req_byte`=0): `rom_word` is 1, `rom_addr` is the word address, `rom_a_lsb_oe` is 0, and `out_data` is the full 16-bit `rom_dq`.
- R6: Byte mode (`req_byte`=1): `rom_word` is 0, `rom_addr` is the byte address shifted right by one, and `rom_a_lsb` (enabled by `rom_a_lsb_oe`=1 while the ROM is selected) is byte-address bit 0. `out_data` is `{8'h00, rom_dq[7:0]}`, so `rom_dq[14:8]` has no effect.
- R7: A request yields exactly `req_len`+1 beats from ascending addresses. `out_last` is 1 on the final beat only.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold, and the ROM address does not advance.
- R9: After the final beat is captured, both enables go high and `req_ready` stays low for `cfg_t_hiz` clocks. Back to back, the ROM therefore sits deselected for `cfg_t_hiz`+1 clocks.
- R10: A timing count of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_t_rand | input | TW | Clocks for a random access |
| cfg_t_page | input | TW | Clocks for an in-page access |
| cfg_t_hiz | input | TW | Turnaround clocks after a burst |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when both high |
| req_addr | input | ADDR_W+1 | Start address (word address in low ADDR_W bits, or byte address) |
| req_len | input | LEN_W | Beats minus one |
| req_byte | input | 1 | 1 = byte mode, 0 = word mode |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_word | output | 1 | ROM mode pin, 1 = word |
| rom_addr | output | ADDR_W | ROM address above the byte bit |
| rom_a_lsb | output | 1 | Byte-address bit 0 for the top data pin |
| rom_a_lsb_oe | output | 1 | Drive enable for the top data pin |
| rom_dq | input | 16 | ROM data |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Beat taken when both high |
| out_data | output | 16 | Beat data |
| out_last | output | 1 | Final beat of the request |

## Verification
The bench builds the controller with a 12-bit word address, so starting near the top of memory reaches the wrap to address zero within a few beats. A 6-bit length field allows bursts long enough to cross several pages. A ROM model in the bench returns garbage unless each address has been stable for the configured counts, so any early sample shows up as a data mismatch. The bench runs the 5/2/1 clock setting, a slower 8/4/2 setting and an all-zero page and turnaround setting. In the zero setting, the treat-zero-as-one rule decides both the burst latency and the standby gap.

// File: rtl/prom_pkg.sv
package prom_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_HIZ    = 2'd2
  } prom_state_e;
endpackage

// File: rtl/prom_timer.sv
module prom_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = (load_val == '0) ? '0 : load_val - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R10
  long_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val > 1) |=> !done);
  // R10
  short_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val <= 1) |=> done);
endmodule

// File: rtl/prom_addr_gen.sv
module prom_addr_gen #(
  parameter int BA_W   = 22,
  parameter int LEN_W  = 6,
  parameter int PAGE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BA_W-1:0]  start_addr,
  input  logic [LEN_W-1:0] start_len,
  input  logic             start_byte,
  input  logic             step,
  output logic [BA_W-1:0]  cur,
  output logic             byte_mode,
  output logic             last,
  output logic             wrap_next
);
  logic [BA_W-1:0]  cur_q, cur_d, nxt;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             mode_q, mode_d;

  assign nxt = cur_q + 1'b1;

  always_comb begin
    cur_d  = cur_q;
    rem_d  = rem_q;
    mode_d = mode_q;
    if (start) begin
      cur_d  = start_addr;
      rem_d  = start_len;
      mode_d = start_byte;
    end else if (step) begin
      cur_d  = nxt;
      rem_d  = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      rem_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      rem_q  <= rem_d;
      mode_q <= mode_d;
    end
  end

  assign cur       = cur_q;
  assign byte_mode = mode_q;
  assign last      = (rem_q == '0);
  assign wrap_next = mode_q ? (nxt[PAGE_W:0] == '0) : (nxt[PAGE_W-1:0] == '0);

  // R7
  no_step_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !last);
  // R7
  step_ascends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start) |=> (cur == $past(cur) + 1'b1));
endmodule

// File: rtl/prom_beat_buf.sv
module prom_beat_buf #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] cap_data,
  input  logic          cap_last,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          free
);
  logic          vld_q, vld_d;
  logic [DW-1:0] dat_q;
  logic          lst_q;

  assign free = !vld_q || out_ready;

  always_comb begin
    vld_d = vld_q;
    if (cap)            vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      lst_q <= 1'b0;
    end else if (cap) begin
      dat_q <= cap_data;
      lst_q <= cap_last;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign out_last  = lst_q;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

// File: rtl/prom_burst_ctrl.sv
module prom_burst_ctrl #(
  parameter int ADDR_W = 21,
  parameter int LEN_W  = 6,
  parameter int TW     = 8,
  parameter int PAGE_W = 3,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     cfg_t_rand,
  input  logic [TW-1:0]     cfg_t_page,
  input  logic [TW-1:0]     cfg_t_hiz,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W:0]   req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_byte,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic              rom_word,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_a_lsb,
  output logic              rom_a_lsb_oe,
  input  logic [DW-1:0]     rom_dq,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              out_last
);
  import prom_pkg::*;

  localparam int BA_W = ADDR_W + 1;
  localparam int HW   = DW / 2;

  prom_state_e    st_q, st_d;
  logic           rand_q, rand_d;
  logic           tmr_load, tmr_done;
  logic [TW-1:0]  tmr_val;
  logic           ag_start, ag_step, ag_last, ag_wrap, ag_byte;
  logic [BA_W-1:0] ag_cur;
  logic           cap, buf_free;
  logic [DW-1:0]  cap_data;

  prom_timer #(.TW(TW)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  prom_addr_gen #(.BA_W(BA_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W)) i_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(ag_start), .start_addr(req_addr),
    .start_len(req_len), .start_byte(req_byte), .step(ag_step),
    .cur(ag_cur), .byte_mode(ag_byte), .last(ag_last), .wrap_next(ag_wrap)
  );

  prom_beat_buf #(.DW(DW)) i_beat_buf (
    .clk(clk), .rst_n(rst_n), .cap(cap), .cap_data(cap_data), .cap_last(ag_last),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .free(buf_free)
  );

  // next-state logic
  always_comb begin
    st_d     = st_q;
    rand_d   = rand_q;
    tmr_load = 1'b0;
    tmr_val  = cfg_t_rand;
    ag_start = 1'b0;
    ag_step  = 1'b0;
    cap      = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d     = ST_ACCESS;
          ag_start = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = cfg_t_rand;
          rand_d   = 1'b1;
        end
      end
      ST_ACCESS: begin
        if (tmr_done && buf_free) begin
          cap      = 1'b1;
          tmr_load = 1'b1;
          if (ag_last) begin
            st_d    = ST_HIZ;
            tmr_val = cfg_t_hiz;
          end else begin
            ag_step = 1'b1;
            if (ag_wrap) begin
              tmr_val = cfg_t_rand;
              rand_d  = 1'b1;
            end else begin
              tmr_val = cfg_t_page;
              rand_d  = 1'b0;
            end
          end
        end
      end
      ST_HIZ: begin
        if (tmr_done) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rand_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rand_q <= rand_d;
    end
  end

  assign cap_data = ag_byte ? {{HW{1'b0}}, rom_dq[HW-1:0]} : rom_dq;

  assign req_ready    = (st_q == ST_IDLE);
  assign rom_ce_n     = (st_q != ST_ACCESS);
  assign rom_oe_n     = (st_q != ST_ACCESS);
  assign rom_word     = !ag_byte;
  assign rom_addr     = ag_byte ? ag_cur[BA_W-1:1] : ag_cur[ADDR_W-1:0];
  assign rom_a_lsb    = ag_byte & ag_cur[0];
  assign rom_a_lsb_oe = ag_byte && (st_q == ST_ACCESS);

  // R1
  standby_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_ce_n |-> rom_oe_n);
  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> rom_ce_n);
  // R3
  page_upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && $past(!rom_ce_n) && !rand_q) |->
      ($stable(rom_addr[ADDR_W-1:PAGE_W]) && $stable(rom_word)));
  // R6
  byte_lsb_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && !rom_word) |-> rom_a_lsb_oe);
  // R5
  word_lsb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_word |-> !rom_a_lsb_oe);
  // R9
  hiz_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_ce_n) |-> !req_ready);
  // R8
  stall_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !rom_ce_n) |=> $stable(ag_cur));
endmodule

// File: tb/test_prom_burst_ctrl.sv
module test_prom_burst_ctrl;
  localparam int ADDR_W = 12;
  localparam int LEN_W  = 6;
  localparam int TW     = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [TW-1:0]     cfg_t_rand = 8'd5, cfg_t_page = 8'd2, cfg_t_hiz = 8'd1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W:0]   req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              req_byte = 1'b0;
  logic              rom_ce_n, rom_oe_n, rom_word, rom_a_lsb, rom_a_lsb_oe;
  logic [ADDR_W-1:0] rom_addr;
  logic [15:0]       rom_dq = 16'hDEAD;
  logic              out_valid, out_last;
  logic              out_ready = 1'b1;
  logic [15:0]       out_data;

  prom_burst_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TW(TW)) i_prom_burst_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_t_rand(cfg_t_rand), .cfg_t_page(cfg_t_page),
    .cfg_t_hiz(cfg_t_hiz), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_byte(req_byte),
    .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_word(rom_word),
    .rom_addr(rom_addr), .rom_a_lsb(rom_a_lsb), .rom_a_lsb_oe(rom_a_lsb_oe),
    .rom_dq(rom_dq), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int t0 = 0, t_last = 0;
  bit bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] exp_data[$];
  logic        exp_last[$];
  string       exp_tag[$];
  int hi_run = 0, last_gap = 0;
  bit done_flag = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] romf(input int unsigned wa);
    int unsigned w;
    w = (wa & ((1 << ADDR_W) - 1)) * 32'h9E37;
    return w[15:0] ^ 16'h5A3C;
  endfunction

  // ROM model: data valid only after the configured settle times
  logic [ADDR_W-1:0] p_addr = '0;
  logic p_lsb = 1'b0, p_ce = 1'b1, p_word = 1'b1;
  int age_r = 0, age_p = 0;
  always @(negedge clk) begin
    logic lsb_e;
    int need_r, need_p;
    logic [15:0] w;
    lsb_e = rom_a_lsb_oe ? rom_a_lsb : 1'b0;
    if (rom_ce_n != p_ce || rom_word != p_word ||
        rom_addr[ADDR_W-1:3] != p_addr[ADDR_W-1:3]) age_r = 1;
    else if (age_r < 1000) age_r++;
    if (age_r == 1 || rom_addr != p_addr || lsb_e != p_lsb) age_p = 1;
    else if (age_p < 1000) age_p++;
    p_ce = rom_ce_n; p_word = rom_word; p_addr = rom_addr; p_lsb = lsb_e;
    need_r = (cfg_t_rand == 0) ? 1 : int'(cfg_t_rand);
    need_p = (cfg_t_page == 0) ? 1 : int'(cfg_t_page);
    if (rom_ce_n || rom_oe_n || age_r < need_r || age_p < need_p) rom_dq = 16'hDEAD;
    else if (rom_word) rom_dq = romf(rom_addr);
    else if (!rom_a_lsb_oe) rom_dq = 16'hDEAD;
    else begin
      w = romf(rom_addr);
      rom_dq = {rom_a_lsb, 7'h55, (rom_a_lsb ? w[15:8] : w[7:0])};
    end
  end

  // ready pattern and scoreboard monitor
  always @(negedge clk) begin
    logic [15:0] ed;
    logic el;
    string tg;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_en ? lfsr[0] : 1'b1;
    if (rst_n && out_valid && out_ready) begin
      if (exp_data.size() == 0) chk(1'b0, "R7 unexpected beat", out_data, 0);
      else begin
        ed = exp_data.pop_front(); el = exp_last.pop_front(); tg = exp_tag.pop_front();
        chk(out_data == ed, tg, out_data, ed);
        chk(out_last == el, "R7 last flag", out_last, el);
        if (out_last) t_last = cyc;
      end
    end
  end

  // standby gap monitor
  always @(negedge clk) begin
    if (rom_ce_n) hi_run++;
    else begin
      if (hi_run > 0) last_gap = hi_run;
      hi_run = 0;
    end
  end

  task automatic send(input int unsigned addr, input int len, input bit byt);
    int unsigned a;
    logic [15:0] w;
    for (int i = 0; i <= len; i++) begin
      a = addr + i;
      if (byt) begin
        a = a & ((1 << (ADDR_W + 1)) - 1);
        w = romf(a >> 1);
        exp_data.push_back({8'h00, (a[0] ? w[15:8] : w[7:0])});
        exp_tag.push_back("R6 byte data");
      end else begin
        exp_data.push_back(romf(a));
        exp_tag.push_back("R5 word data");
      end
      exp_last.push_back(i == len);
    end
    @(negedge clk);
    req_addr = addr[ADDR_W:0]; req_len = len[LEN_W-1:0]; req_byte = byt; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    t0 = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!rom_ce_n && !rom_oe_n, "R2 enables low together", {rom_ce_n, rom_oe_n}, 0);
    a = byt ? (addr >> 1) : addr;
    chk(rom_addr == a[ADDR_W-1:0], "R2 start address", rom_addr, a[ADDR_W-1:0]);
    chk(rom_word == !byt, byt ? "R6 mode pin" : "R5 mode pin", rom_word, !byt);
    chk(rom_a_lsb_oe == byt, byt ? "R6 lsb drive" : "R5 lsb quiet", rom_a_lsb_oe, byt);
  endtask

  task automatic drain();
    while (exp_data.size() != 0) @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic burst(input int unsigned addr, input int len, input bit byt,
                       input int lat, input string tag);
    send(addr, len, byt);
    drain();
    if (lat >= 0) chk(t_last - t0 == lat, tag, t_last - t0, lat);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rom_ce_n && rom_oe_n, "R1 reset enables", {rom_ce_n, rom_oe_n}, 2'b11);
    chk(!out_valid, "R1 reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && rom_ce_n, "R1 idle standby", {req_ready, rom_ce_n}, 2'b11);

    // 5/2/1 clocks
    burst(32'h010, 7, 1'b0, 5 + 7 * 2, "R3 word page latency");
    burst(32'h026, 3, 1'b0, 5 + 2 + 5 + 2, "R4 word page split latency");
    burst(32'h040, 15, 1'b1, 5 + 15 * 2, "R6 R3 byte page latency");
    burst(32'h05E, 3, 1'b1, 5 + 2 + 5 + 2, "R4 byte page split latency");
    burst(32'hFFE, 3, 1'b0, 5 + 2 + 5 + 2, "R4 top wrap latency");
    burst(32'h123, 0, 1'b0, 5, "R7 single beat latency");
    chk(rom_ce_n && req_ready, "R1 standby after burst", {rom_ce_n, req_ready}, 2'b11);

    // back-pressure
    bp_en = 1'b1;
    burst(32'h203, 40, 1'b0, -1, "R8");
    burst(32'h417, 33, 1'b1, -1, "R8");
    bp_en = 1'b0;

    // turnaround gap back to back
    cfg_t_hiz = 8'd3;
    send(32'h300, 0, 1'b0);
    send(32'h301, 0, 1'b0);
    drain();
    chk(last_gap == 4, "R9 standby gap", last_gap, 4);

    // slower grade
    cfg_t_rand = 8'd8; cfg_t_page = 8'd4; cfg_t_hiz = 8'd2;
    burst(32'h088, 2, 1'b0, 8 + 4 + 4, "R2 R3 slow grade latency");

    // zero counts act as one
    cfg_t_rand = 8'd5; cfg_t_page = 8'd0; cfg_t_hiz = 8'd0;
    burst(32'h0A0, 7, 1'b0, 5 + 7, "R10 zero page count");
    send(32'h310, 0, 1'b1);
    send(32'h311, 0, 1'b1);
    drain();
    chk(last_gap == 2, "R10 zero turnaround gap", last_gap, 2);

    done_flag = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule